// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block drives the control wires of up to four power-gated domains. Each domain has its own sequencer, and each sequencer works on its own. A power-down request takes a domain through three steps. First an optional retention capture pulse, then the isolation clamp, then the supply cut. A power-up request runs the same steps in the opposite order: the supply comes back, an optional restore pulse reloads the retained state, and the isolation is released last. Two parameters fix the timing in clock cycles. One sets the width of the capture and restore pulses. The other sets the wait between two phases.

Each domain has eight states:

| State | Meaning |
|---|---|
| `PS_ON` | Domain on. |
| `PS_SAVE` | Capture pulse, lasts `PULSE_W` cycles. |
| `PS_SAVE_GAP` | Quiet gap, lasts `GAP_W` cycles. |
| `PS_ISO_WAIT` | Clamp raised, supply still on, lasts `GAP_W` cycles. |
| `PS_OFF` | Supply cut. |
| `PS_RAMP` | Supply back on, clamp held, lasts `GAP_W` cycles. |
| `PS_RESTORE` | Restore pulse, lasts `PULSE_W` cycles. |
| `PS_SETTLE` | Clamp still held after the restore, lasts `GAP_W` cycles. |

The transitions are:

| From | To | Condition |
|---|---|---|
| `PS_ON` | `PS_SAVE` | Power-down wanted and retention enabled. |
| `PS_ON` | `PS_ISO_WAIT` | Power-down wanted and retention disabled. |
| `PS_SAVE` | `PS_SAVE_GAP` | Timer expired. |
| `PS_SAVE_GAP` | `PS_ISO_WAIT` | Timer expired. |
| `PS_ISO_WAIT` | `PS_OFF` | Timer expired. |
| `PS_OFF` | `PS_RAMP` | Power-up wanted. |
| `PS_RAMP` | `PS_RESTORE` | Timer expired and the domain was saved on the way down. |
| `PS_RAMP` | `PS_ON` | Timer expired and the domain was not saved on the way down. |
| `PS_RESTORE` | `PS_SETTLE` | Timer expired. |
| `PS_SETTLE` | `PS_ON` | Timer expired. |

Requests are sampled every cycle. A request seen during a sequence is held until the domain reaches `PS_ON` or `PS_OFF`.

Top module: `pgs_manager`

## Requirements
- R1: After reset every domain has `st_on`=1 and `st_off`=0, with isolate, supply_cut, save_pulse and restore_pulse all at 0.
- R2: Power-down with retention runs in this order, where k is the clock edge that samples the request:
  - save_pulse is high for `PULSE_W` cycles from edge k;
  - then all controls stay low for `GAP_W` cycles;
  - then isolate alone is high for `GAP_W` cycles;
  - then supply_cut and `st_off` rise, and isolate stays high.
- R3: Power-down without retention starts with isolate high for `GAP_W` cycles from edge k, and save_pulse never rises. Then supply_cut and `st_off` rise.
- R4: Power-up of a domain that was saved runs in this order from edge k:
  - supply_cut falls while isolate stays high, for `GAP_W` cycles;
  - then restore_pulse is high for `PULSE_W` cycles;
  - then isolate alone is high for `GAP_W` more cycles;
  - then isolate falls and `st_on` rises.
- R5: Power-up of a domain that was not saved drops supply_cut at edge k and holds isolate for `GAP_W` cycles. Then isolate falls and `st_on` rises, and restore_pulse never rises.
- R6: The retain_en input is sampled only at the edge that starts a power-down. Whether the next power-up pulses restore depends on that sample alone, and the value of retain_en during power-up has no effect.
- R7: A request that arrives during a sequence is held. It starts at the first clock edge after the domain reaches its stable on or off state, which leaves that stable state visible for exactly one cycle.
- R8: A power-down request to a domain that is already off, or a power-up request to a domain that is already on, is dropped. It leaves no pending effect.
- R9: `st_off` is high only while supply_cut is high. `st_on` is high only while both isolate and supply_cut are low. Neither is high during a sequence.
- R10: Each domain sequences independently. Activity on one domain leaves the outputs of the others unchanged.
- R11: Three safety rules hold at all times:
  - supply_cut is never high without isolate;
  - save_pulse is high only while the domain is powered and not isolated;
  - restore_pulse is high only while the domain is powered and isolated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_req | input | NDOM | Power-down request, one bit per domain |
| pu_req | input | NDOM | Power-up request, one bit per domain |
| retain_en | input | NDOM | Request state retention for the next power-down |
| save_pulse | output | NDOM | Retention capture pulse |
| restore_pulse | output | NDOM | Retention reload pulse |
| isolate | output | NDOM | Isolation clamp enable |
| supply_cut | output | NDOM | Power switch off (1 = supply removed) |
| st_on | output | NDOM | Domain fully on |
| st_off | output | NDOM | Domain fully off |

## Verification
The assertions assume that `PULSE_W` and `GAP_W` are at least one and that reset is applied before the first request. Nothing else is assumed about the request pins. The ordering and status properties must therefore hold for any pattern of requests, including both requests in the same cycle.

The stimulus uses one-cycle request pulses. It issues a new request only once the domain under test is stable, except in the deliberate overlap case. This keeps every cycle of the expected waveform computable from the two timing parameters.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    typedef enum logic [2:0] {
        PS_ON,
        PS_SAVE,
        PS_SAVE_GAP,
        PS_ISO_WAIT,
        PS_OFF,
        PS_RAMP,
        PS_RESTORE,
        PS_SETTLE
    } pgs_state_e;

    typedef struct packed {
        logic save;
        logic restore;
        logic iso;
        logic cut;
        logic on;
        logic off;
    } pgs_ctl_t;

endpackage

// File: rtl/pgs_phase_timer.sv
module pgs_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/pgs_req_hold.sv
module pgs_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    input  logic clear,
    output logic want
);

    logic pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (clear) begin
            pend <= 1'b0;
        end else if (req_in) begin
            pend <= 1'b1;
        end
    end

    // A request in the current cycle counts at once; an earlier one is held.
    assign want = pend | req_in;

endmodule

// File: rtl/pgs_domain_fsm.sv
module pgs_domain_fsm
    import pgs_pkg::*;
#(
    parameter int PULSE_W = 4,
    parameter int GAP_W   = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pd_req,
    input  logic     pu_req,
    input  logic     retain_en,
    output pgs_ctl_t ctl
);

    localparam int LONGEST = (PULSE_W > GAP_W) ? PULSE_W : GAP_W;
    localparam int CW      = $clog2(LONGEST + 1);
    localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_W - 1);
    localparam logic [CW-1:0] GAP_LD   = CW'(GAP_W - 1);

    pgs_state_e    st, st_nxt;
    logic          ld;
    logic [CW-1:0] ld_val;
    logic          expired;
    logic          dn_want, up_want;
    logic          stable;
    logic          kept;

    assign stable = (st == PS_ON) || (st == PS_OFF);

    pgs_req_hold u_dn_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (pd_req),
        .clear  (stable),
        .want   (dn_want)
    );

    pgs_req_hold u_up_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (pu_req),
        .clear  (stable),
        .want   (up_want)
    );

    pgs_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .expired  (expired)
    );

    // State register and retention sample.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= PS_ON;
            kept <= 1'b0;
        end else begin
            st <= st_nxt;
            if (st == PS_ON && dn_want) begin
                kept <= retain_en;
            end
        end
    end

    // Transition logic.
    always_comb begin
        st_nxt = st;
        ld     = 1'b0;
        ld_val = '0;
        unique case (st)
            PS_ON: begin
                if (dn_want) begin
                    ld = 1'b1;
                    if (retain_en) begin
                        st_nxt = PS_SAVE;
                        ld_val = PULSE_LD;
                    end else begin
                        st_nxt = PS_ISO_WAIT;
                        ld_val = GAP_LD;
                    end
                end
            end
            PS_SAVE: begin
                if (expired) begin
                    st_nxt = PS_SAVE_GAP;
                    ld     = 1'b1;
                    ld_val = GAP_LD;
                end
            end
            PS_SAVE_GAP: begin
                if (expired) begin
                    st_nxt = PS_ISO_WAIT;
                    ld     = 1'b1;
                    ld_val = GAP_LD;
                end
            end
            PS_ISO_WAIT: begin
                if (expired) begin
                    st_nxt = PS_OFF;
                end
            end
            PS_OFF: begin
                if (up_want) begin
                    st_nxt = PS_RAMP;
                    ld     = 1'b1;
                    ld_val = GAP_LD;
                end
            end
            PS_RAMP: begin
                if (expired) begin
                    if (kept) begin
                        st_nxt = PS_RESTORE;
                        ld     = 1'b1;
                        ld_val = PULSE_LD;
                    end else begin
                        st_nxt = PS_ON;
                    end
                end
            end
            PS_RESTORE: begin
                if (expired) begin
                    st_nxt = PS_SETTLE;
                    ld     = 1'b1;
                    ld_val = GAP_LD;
                end
            end
            PS_SETTLE: begin
                if (expired) begin
                    st_nxt = PS_ON;
                end
            end
            default: st_nxt = PS_ON;
        endcase
    end

    // Output decode.
    always_comb begin
        ctl = '0;
        unique case (st)
            PS_ON:       ctl.on = 1'b1;
            PS_SAVE:     ctl.save = 1'b1;
            PS_SAVE_GAP: ctl = '0;
            PS_ISO_WAIT: ctl.iso = 1'b1;
            PS_OFF: begin
                ctl.iso = 1'b1;
                ctl.cut = 1'b1;
                ctl.off = 1'b1;
            end
            PS_RAMP:     ctl.iso = 1'b1;
            PS_RESTORE: begin
                ctl.iso     = 1'b1;
                ctl.restore = 1'b1;
            end
            PS_SETTLE:   ctl.iso = 1'b1;
            default:     ctl = '0;
        endcase
    end

endmodule

// File: rtl/pgs_manager.sv
module pgs_manager
    import pgs_pkg::*;
#(
    parameter int NDOM    = 4,
    parameter int PULSE_W = 4,
    parameter int GAP_W   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NDOM-1:0] pd_req,
    input  logic [NDOM-1:0] pu_req,
    input  logic [NDOM-1:0] retain_en,
    output logic [NDOM-1:0] save_pulse,
    output logic [NDOM-1:0] restore_pulse,
    output logic [NDOM-1:0] isolate,
    output logic [NDOM-1:0] supply_cut,
    output logic [NDOM-1:0] st_on,
    output logic [NDOM-1:0] st_off
);

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        pgs_ctl_t ctl;

        pgs_domain_fsm #(
            .PULSE_W (PULSE_W),
            .GAP_W   (GAP_W)
        ) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .pd_req    (pd_req[d]),
            .pu_req    (pu_req[d]),
            .retain_en (retain_en[d]),
            .ctl       (ctl)
        );

        assign save_pulse[d]    = ctl.save;
        assign restore_pulse[d] = ctl.restore;
        assign isolate[d]       = ctl.iso;
        assign supply_cut[d]    = ctl.cut;
        assign st_on[d]         = ctl.on;
        assign st_off[d]        = ctl.off;
    end

endmodule

// File: rtl/pgs_manager_chk.sv
module pgs_manager_chk #(
    parameter int NDOM = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NDOM-1:0] save_pulse,
    input logic [NDOM-1:0] restore_pulse,
    input logic [NDOM-1:0] isolate,
    input logic [NDOM-1:0] supply_cut,
    input logic [NDOM-1:0] st_on,
    input logic [NDOM-1:0] st_off
);

    for (genvar d = 0; d < NDOM; d++) begin : g_chk
        a_r11_cut_needs_iso: assert property (@(posedge clk) disable iff (!rst_n)
            supply_cut[d] |-> isolate[d]);

        a_r11_save_open: assert property (@(posedge clk) disable iff (!rst_n)
            save_pulse[d] |-> (!isolate[d] && !supply_cut[d]));

        a_r11_restore_clamped: assert property (@(posedge clk) disable iff (!rst_n)
            restore_pulse[d] |-> (isolate[d] && !supply_cut[d]));

        a_r2_iso_before_cut: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(supply_cut[d]) |-> $past(isolate[d]));

        a_r4_release_after_power: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(isolate[d]) |-> (!supply_cut[d] && $past(!supply_cut[d])));

        a_r9_off_status: assert property (@(posedge clk) disable iff (!rst_n)
            st_off[d] |-> supply_cut[d]);

        a_r9_on_status: assert property (@(posedge clk) disable iff (!rst_n)
            st_on[d] |-> (!isolate[d] && !supply_cut[d]));

        a_r11_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            !(save_pulse[d] && restore_pulse[d]));
    end

endmodule

bind pgs_manager pgs_manager_chk #(.NDOM(NDOM)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .save_pulse    (save_pulse),
    .restore_pulse (restore_pulse),
    .isolate       (isolate),
    .supply_cut    (supply_cut),
    .st_on         (st_on),
    .st_off        (st_off)
);

// File: tb/test_pgs_manager.sv
`timescale 1ns/1ps
module test_pgs_manager;

    localparam int NDOM = 2;
    localparam int PW   = 2;
    localparam int GW   = 3;
    localparam logic [5:0] ON_V  = 6'b000010;
    localparam logic [5:0] OFF_V = 6'b001101;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NDOM-1:0] pd_req = '0;
    logic [NDOM-1:0] pu_req = '0;
    logic [NDOM-1:0] retain_en = '0;
    logic [NDOM-1:0] save_pulse, restore_pulse, isolate, supply_cut, st_on, st_off;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pgs_manager #(.NDOM(NDOM), .PULSE_W(PW), .GAP_W(GW)) i_pgs_manager (
        .clk           (clk),
        .rst_n         (rst_n),
        .pd_req        (pd_req),
        .pu_req        (pu_req),
        .retain_en     (retain_en),
        .save_pulse    (save_pulse),
        .restore_pulse (restore_pulse),
        .isolate       (isolate),
        .supply_cut    (supply_cut),
        .st_on         (st_on),
        .st_off        (st_off)
    );

    function automatic logic [5:0] obs(input int d);
        return {save_pulse[d], restore_pulse[d], isolate[d], supply_cut[d], st_on[d], st_off[d]};
    endfunction

    // Expected {save,restore,iso,cut,on,off} t samples after the request edge.
    function automatic logic [5:0] exp_ctl(input bit dn, input bit kept, input int t);
        if (dn && kept) begin
            if (t <= PW)        return 6'b100000;
            if (t <= PW + GW)   return 6'b000000;
            if (t <= PW + 2*GW) return 6'b001000;
            return OFF_V;
        end else if (dn) begin
            if (t <= GW) return 6'b001000;
            return OFF_V;
        end else if (kept) begin
            if (t <= GW)        return 6'b001000;
            if (t <= GW + PW)   return 6'b011000;
            if (t <= 2*GW + PW) return 6'b001000;
            return ON_V;
        end else begin
            if (t <= GW) return 6'b001000;
            return ON_V;
        end
    endfunction

    task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic run_seq(input int d, input bit dn, input bit keep_in, input bit kept_exp,
                           input logic [5:0] other_exp, input string tag);
        retain_en[d] = keep_in;
        if (dn) pd_req[d] = 1'b1; else pu_req[d] = 1'b1;
        tick();
        pd_req[d] = 1'b0;
        pu_req[d] = 1'b0;
        for (int t = 1; t <= PW + 2*GW + 2; t++) begin
            check(tag, obs(d), exp_ctl(dn, kept_exp, t));
            check("R10 other domain", obs(1 - d), other_exp);
            tick();
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1;
        check("R1 reset d0", obs(0), ON_V);
        check("R1 reset d1", obs(1), ON_V);
        #20;
        rst_n = 1'b1;
        tick();
        check("R1 after release d0", obs(0), ON_V);
        check("R1 after release d1", obs(1), ON_V);

        // Sweep domains and retention modes.
        for (int d = 0; d < NDOM; d++) begin
            for (int k = 0; k < 2; k++) begin
                run_seq(d, 1'b1, k[0], k[0], ON_V, k[0] ? "R2 R9 R11 down" : "R3 R9 R11 down");
                run_seq(d, 1'b0, k[0], k[0], ON_V, k[0] ? "R4 R9 R11 up" : "R5 R9 R11 up");
            end
        end

        // R6: retention flag matters only at the start of power-down.
        run_seq(0, 1'b1, 1'b1, 1'b1, ON_V, "R6 down saved");
        run_seq(0, 1'b0, 1'b0, 1'b1, ON_V, "R6 up restore kept");
        run_seq(0, 1'b1, 1'b0, 1'b0, ON_V, "R6 down unsaved");
        run_seq(0, 1'b0, 1'b1, 1'b0, ON_V, "R6 up no restore");

        // R7: power-up request held during a power-down.
        retain_en[0] = 1'b1;
        pd_req[0] = 1'b1;
        tick();
        pd_req[0] = 1'b0;
        for (int t = 1; t <= 2*(PW + 2*GW) + 3; t++) begin
            if (t <= PW + 2*GW + 1)
                check("R7 held down", obs(0), exp_ctl(1'b1, 1'b1, t));
            else
                check("R7 held up", obs(0), exp_ctl(1'b0, 1'b1, t - (PW + 2*GW + 1)));
            if (t == 2) pu_req[0] = 1'b1;
            tick();
            pu_req[0] = 1'b0;
        end

        // R8: requests for the state already held are dropped.
        run_seq(1, 1'b1, 1'b0, 1'b0, ON_V, "R8 setup down");
        pd_req[1] = 1'b1;
        tick();
        pd_req[1] = 1'b0;
        for (int t = 0; t < PW + 2*GW + 2; t++) begin
            check("R8 down while off", obs(1), OFF_V);
            tick();
        end
        run_seq(1, 1'b0, 1'b0, 1'b0, ON_V, "R8 up");
        for (int t = 0; t < 4; t++) begin
            check("R8 no stale down", obs(1), ON_V);
            tick();
        end
        pu_req[1] = 1'b1;
        tick();
        pu_req[1] = 1'b0;
        for (int t = 0; t < PW + 2*GW + 2; t++) begin
            check("R8 up while on", obs(1), ON_V);
            tick();
        end
        run_seq(1, 1'b1, 1'b0, 1'b0, ON_V, "R8 R3 fresh down");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule